// File: doc/BRIEF.md
# Neighborhood Energy Threshold Detector

The block watches a raster-ordered stream of per-pixel normalized energy values taken from a pixel array of 16 lines by 192 columns. Pixels arrive left to right within a line and top to bottom within a frame, and the scan restarts with the next frame. Each input word carries its pixel index. Two line stores keep the two lines above the current one. A three-wide shift register for each of the three lines forms a 3x3 neighborhood whose bottom-right corner is the pixel just accepted. The nine energies are summed, clamped to the sum register's width, and compared with a threshold. The result is a one-bit detection flag for that neighborhood.

Each accepted sample produces exactly one result, paired with a frame marker that is high only for the result of pixel 0. The clock, the marker and the detection bit together locate every detection in space and time. A neighborhood that would reach past the left column edge, or above the top of the frame, never reports a detection. Only the 14 x 190 complete positions can fire.

A scan controller with three states governs acceptance. `S_WAIT` is the state after reset. It drops every sample until pixel 0 arrives. That arrival is the frame_lock transition to `S_FILL`, which covers lines 0 and 1. The first accepted sample in line 2 or below is the rows_primed transition to `S_EVAL`. Pixel 0 of the next frame is the frame_wrap transition from `S_EVAL` back to `S_FILL`. A repeated pixel 0 while in `S_FILL` stays in `S_FILL`.

Top module: `nbd_detect`

## Requirements
- R1: An accepted sample with index `i` belongs to line `i / 192` and column `i % 192`. Its result appears on `out_valid`, `det_flag` and `sync_flag` two rising edges after the edge that accepts it.
- R2: For a sample at line `r >= 2` and column `c >= 2`, `det_flag` is 1 exactly when the sum of the energies at lines `r-2..r` and columns `c-2..c` of the current frame is at least `thr`, and 0 otherwise.
- R3: The nine-value sum never wraps. Nine inputs of 65535 with `thr` = 65535 give `det_flag` = 1, because the 18-bit sum saturates at its all-ones value.
- R4: `det_flag` is 0 for every sample in column 0 or 1.
- R5: `det_flag` is 0 for every sample in line 0 or 1 of a frame.
- R6: `sync_flag` is 1 only on the result for pixel index 0, and 0 for every other result.
- R7: After reset, samples are dropped with no result until a sample with index 0 arrives.
- R8: Exactly one result (`out_valid` = 1) is produced for each accepted sample, including back-to-back samples. Cycles with `in_valid` low produce no result.
- R9: While reset is asserted, `out_valid`, `det_flag` and `sync_flag` are 0.
- R10: A sum exactly equal to `thr` gives a detection. A threshold one greater than the same sum gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_idx` and `in_energy` as a sample |
| in_idx | input | 12 | Raster pixel index of the sample, 0 to 3071 |
| in_energy | input | 16 | Normalized pixel energy, unsigned |
| thr | input | 16 | Detection threshold, unsigned, compared with `>=` |
| out_valid | output | 1 | One result is present this cycle |
| det_flag | output | 1 | Neighborhood sum reached the threshold |
| sync_flag | output | 1 | Result belongs to pixel 0 of a frame |

## Verification
The result for a sample is due two rising edges after the edge that accepts it: one edge loads the window taps and gating flags, and the next loads the output flags. The bench therefore records the expected valid, detection and marker bits for the sample it presents at each falling edge. It compares them with the outputs two falling edges later, so both missing results and late results are caught. A dropped sample, or a cycle with no sample, places an expected idle entry in the same pipeline, so a stray `out_valid` is caught at the exact cycle it would appear. The threshold is changed only after the pipeline has drained, so every comparison uses the value that was present when that sample was accepted.

// File: rtl/nbd_pkg.sv
package nbd_pkg;

    // Scan controller states
    typedef enum logic [1:0] {
        S_WAIT = 2'd0,   // no frame start seen yet, samples dropped
        S_FILL = 2'd1,   // lines 0 and 1 of a frame, windows incomplete
        S_EVAL = 2'd2    // line 2 and below, windows may be evaluated
    } scan_state_t;

    // Number of extra sum bits needed to add nine operands
    localparam int unsigned NBD_GROW = 4;

endpackage

// File: rtl/nbd_ctrl.sv
module nbd_ctrl
    import nbd_pkg::*;
#(
    parameter int COLS  = 192,
    parameter int IDX_W = 12,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    output logic             accept,
    output logic [COL_W-1:0] col,
    output logic             win_ok,
    output logic             first_px
);

    localparam logic [IDX_W-1:0] COLS_I  = IDX_W'(COLS);
    localparam logic [IDX_W-1:0] LINE2_I = IDX_W'(2 * COLS);

    scan_state_t state, nxt_state;
    logic        is_zero;
    logic        row_ge2;

    assign is_zero = (in_idx == '0);
    assign row_ge2 = (in_idx >= LINE2_I);
    assign col     = COL_W'(in_idx % COLS_I);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_WAIT;
        end else begin
            state <= nxt_state;
        end
    end

    // Transitions: frame_lock, rows_primed, frame_wrap
    always_comb begin
        nxt_state = state;
        unique case (state)
            S_WAIT: begin
                if (in_valid && is_zero) nxt_state = S_FILL;       // frame_lock
            end
            S_FILL: begin
                if (in_valid && is_zero)       nxt_state = S_FILL;
                else if (in_valid && row_ge2)  nxt_state = S_EVAL; // rows_primed
            end
            S_EVAL: begin
                if (in_valid && is_zero) nxt_state = S_FILL;       // frame_wrap
            end
            default: nxt_state = S_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        accept = 1'b0;
        unique case (state)
            S_WAIT:  accept = in_valid && is_zero;
            S_FILL:  accept = in_valid;
            S_EVAL:  accept = in_valid;
            default: accept = 1'b0;
        endcase
        first_px = accept && is_zero;
        win_ok   = accept && (nxt_state == S_EVAL) && (col >= COL_W'(2));
    end

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !(in_valid && is_zero)) |=> (state == S_WAIT)); // R7

    AST_FRAME_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_zero) |=> (state == S_FILL)); // R6

endmodule

// File: rtl/nbd_line_store.sv
module nbd_line_store #(
    parameter int COLS   = 192,
    parameter int DATA_W = 16,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] up1,
    output logic [DATA_W-1:0] up2
);

    // Two line memories: line r-1 and line r-2 at each column
    logic [DATA_W-1:0] line1_q [COLS];
    logic [DATA_W-1:0] line2_q [COLS];

    assign up1 = line1_q[col];
    assign up2 = line2_q[col];

    // Each write moves the column down one line and stores the new sample
    always_ff @(posedge clk) begin
        if (wr_en) begin
            line2_q[col] <= line1_q[col];
            line1_q[col] <= din;
        end
    end

endmodule

// File: rtl/nbd_window.sv
module nbd_window
    import nbd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SUM_W  = 18,
    localparam int FULL_W = DATA_W + NBD_GROW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shift_en,
    input  logic [2:0][DATA_W-1:0] col_in,   // [0]=line r-2, [1]=r-1, [2]=r
    output logic [SUM_W-1:0]       sum_o
);

    logic [FULL_W-1:0] row_sum [3];
    logic [FULL_W-1:0] full_sum;

    for (genvar r = 0; r < 3; r++) begin : g_row
        logic [2:0][DATA_W-1:0] tap_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tap_q <= '0;
            end else if (shift_en) begin
                tap_q <= {tap_q[1:0], col_in[r]};
            end
        end

        assign row_sum[r] = FULL_W'(tap_q[0]) + FULL_W'(tap_q[1]) + FULL_W'(tap_q[2]);
    end

    assign full_sum = row_sum[0] + row_sum[1] + row_sum[2];

    if (SUM_W >= FULL_W) begin : g_wide
        assign sum_o = SUM_W'(full_sum);
    end else begin : g_clamp
        localparam logic [FULL_W-1:0] CAP = FULL_W'({SUM_W{1'b1}});
        assign sum_o = (full_sum > CAP) ? {SUM_W{1'b1}} : full_sum[SUM_W-1:0];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o >= SUM_W'(g_row[0].tap_q[0])); // R3

    AST_SUM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o >= SUM_W'(g_row[2].tap_q[2])); // R3

endmodule

// File: rtl/nbd_detect.sv
module nbd_detect
    import nbd_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int COLS   = 192,
    parameter int DATA_W = 16,
    parameter int THR_W  = 16,
    parameter int SUM_W  = 18,
    localparam int IDX_W = $clog2(ROWS * COLS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_energy,
    input  logic [THR_W-1:0]  thr,
    output logic              out_valid,
    output logic              det_flag,
    output logic              sync_flag
);

    logic                   accept;
    logic                   win_ok;
    logic                   first_px;
    logic [COL_W-1:0]       col;
    logic [DATA_W-1:0]      up1, up2;
    logic [SUM_W-1:0]       win_sum;
    logic [2:0][DATA_W-1:0] col_vec;

    logic v1_q, ok1_q, ssb1_q;

    nbd_ctrl #(
        .COLS  (COLS),
        .IDX_W (IDX_W),
        .COL_W (COL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_idx   (in_idx),
        .accept   (accept),
        .col      (col),
        .win_ok   (win_ok),
        .first_px (first_px)
    );

    nbd_line_store #(
        .COLS   (COLS),
        .DATA_W (DATA_W),
        .COL_W  (COL_W)
    ) u_lines (
        .clk   (clk),
        .wr_en (accept),
        .col   (col),
        .din   (in_energy),
        .up1   (up1),
        .up2   (up2)
    );

    assign col_vec = {in_energy, up1, up2};

    nbd_window #(
        .DATA_W (DATA_W),
        .SUM_W  (SUM_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .col_in   (col_vec),
        .sum_o    (win_sum)
    );

    // Stage 1: gating flags travel alongside the window taps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q   <= 1'b0;
            ok1_q  <= 1'b0;
            ssb1_q <= 1'b0;
        end else begin
            v1_q   <= accept;
            ok1_q  <= win_ok;
            ssb1_q <= first_px;
        end
    end

    // Stage 2: compare and register the outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            det_flag  <= 1'b0;
            sync_flag <= 1'b0;
        end else begin
            out_valid <= v1_q;
            det_flag  <= v1_q && ok1_q && (win_sum >= SUM_W'(thr));
            sync_flag <= v1_q && ssb1_q;
        end
    end

    AST_DET_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        det_flag |-> out_valid); // R8

    AST_SYNC_NO_DET: assert property (@(posedge clk) disable iff (!rst_n)
        sync_flag |-> !det_flag); // R5

    AST_FIRST_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_idx == '0) |-> ##2 (out_valid && sync_flag)); // R6

    AST_COL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && col < COL_W'(2)) |-> ##2 !det_flag); // R4

    AST_ROW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_idx < IDX_W'(2 * COLS)) |-> ##2 !det_flag); // R5

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##2 out_valid); // R8

endmodule

// File: tb/sim_nbd_detect.sv
module sim_nbd_detect;

    localparam int ROWS = 16;
    localparam int COLS = 192;
    localparam int PIX  = ROWS * COLS;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [11:0] in_idx;
    logic [15:0] in_energy;
    logic [15:0] thr;
    logic        out_valid, det_flag, sync_flag;

    always #5 clk = ~clk;

    nbd_detect u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_idx    (in_idx),
        .in_energy (in_energy),
        .thr       (thr),
        .out_valid (out_valid),
        .det_flag  (det_flag),
        .sync_flag (sync_flag)
    );

    int unsigned model [PIX];
    int    checks   = 0;
    int    fails    = 0;
    int    cyc      = 0;
    bit    finished = 0;
    bit    waiting  = 1;
    bit    frame_max = 0;
    bit    ev0, ed0, es0, ev1, ed1, es1;
    string tag0 = "R8", tag1 = "R8";

    function automatic int unsigned win_sum(int r, int c);
        int unsigned s = 0;
        for (int rr = r - 2; rr <= r; rr++)
            for (int cc = c - 2; cc <= c; cc++)
                s += model[rr * COLS + cc];
        return s;
    endfunction

    // Expected results run through a two-entry pipeline matching the latency
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            waiting = 1;
            ev0 = 0; ed0 = 0; es0 = 0;
            ev1 = 0; ed1 = 0; es1 = 0;
        end else begin
            if (ev1 || out_valid) begin
                checks++;
                if (out_valid !== ev1 || det_flag !== ed1 || sync_flag !== es1) begin
                    fails++;
                    $display("FAIL %s: valid/det/sync = %0b/%0b/%0b expected %0b/%0b/%0b",
                             tag1, out_valid, det_flag, sync_flag, ev1, ed1, es1);
                end
            end
            ev1 = ev0; ed1 = ed0; es1 = es0; tag1 = tag0;
            ev0 = 0; ed0 = 0; es0 = 0; tag0 = "R8";
            if (in_valid) begin
                if (waiting && in_idx != 0) begin
                    tag0 = "R7";
                end else begin
                    int r, c;
                    int unsigned s;
                    if (in_idx == 0) waiting = 0;
                    model[in_idx] = in_energy;
                    r = int'(in_idx) / COLS;
                    c = int'(in_idx) % COLS;
                    ev0 = 1;
                    es0 = (in_idx == 0);
                    if (es0)        tag0 = "R6";
                    else if (r < 2) tag0 = "R5";
                    else if (c < 2) tag0 = "R4";
                    else begin
                        s   = win_sum(r, c);
                        ed0 = (s >= thr);
                        if (frame_max)      tag0 = "R3";
                        else if (s == thr)  tag0 = "R10";
                        else                tag0 = "R2 R1";
                    end
                end
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R8: cycle %0d expected completion before 150000", cyc);
            summary();
        end
    end

    task automatic drive(bit v, int idx, int unsigned d);
        @(posedge clk);
        #2;
        in_valid  = v;
        in_idx    = idx[11:0];
        in_energy = d[15:0];
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) drive(0, 0, 0);
    endtask

    // mode 0: random around threshold, 1: all maximum, 2: constant 1000
    task automatic send_frame(int mode, int gap, logic [15:0] t);
        idle(4);
        thr       = t;
        frame_max = (mode == 1);
        idle(1);
        for (int i = 0; i < PIX; i++) begin
            int unsigned v;
            while ($urandom_range(0, 99) < gap) idle(1);
            case (mode)
                0:       v = $urandom_range(0, 4800);
                1:       v = 65535;
                default: v = 1000;
            endcase
            drive(1, i, v);
        end
        idle(4);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 0; in_valid = 0; in_idx = '0; in_energy = '0; thr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || det_flag !== 0 || sync_flag !== 0) begin
            fails++;
            $display("FAIL R9: valid/det/sync = %0b/%0b/%0b expected 0/0/0",
                     out_valid, det_flag, sync_flag);
        end
        @(posedge clk);
        #2 rst_n = 1;
        idle(2);
        // R7: samples before any frame start are dropped
        drive(1, 100, 30000);
        drive(1, 101, 30000);
        drive(1, 500, 30000);
        idle(4);
        send_frame(0, 25, 16'd21658);   // R1 R2 R4 R5 R6 with gaps
        send_frame(0, 0, 16'd21658);    // R8 back-to-back
        send_frame(1, 10, 16'hFFFF);    // R3 saturation
        send_frame(2, 5, 16'd9000);     // R10 equality detects
        send_frame(2, 0, 16'd9001);     // R10 one above: no detection
        idle(6);
        summary();
    end

endmodule